// File: doc/BRIEF.md
# Firmware Download Register Block

This block sits on a simple register bus and lets a host processor fill the program memory of an embedded controller with a firmware image, one 32-bit word per transfer. Software opens a download session by setting an enable bit. For each word it writes the value into a data register and raises a request bit in the control/status register. It then polls until the hardware drops that request bit, which shows the word has been written into program memory. After the last word, software clears the enable bit. A short time later a sticky completion flag rises, and from then on the loaded image is protected against any reload.

A session may only be opened while both PLL lock inputs are high. Software reads their state from a status register. The block also holds three interrupt-enable bits that drive an output vector. The program memory is an internal array. The controller reads it through a registered fetch port.

Top module: `fwload_regif`

## Requirements
- R1: After a synchronous active-high reset, the control/status register (0x250), the data register (0x258), the interrupt-enable register (0x224) and `int_en` read zero, `fw_loaded` is low and the word address is zero.
- R2: A read of 0x104 returns `pll_ss_lock` in bit 16 and `pll_hs_lock` in bit 0, with every other bit zero. A read of any undefined offset returns zero. Read data is zero whenever `bus_re` is low.
- R3: Bits 2:0 of 0x224 are read-write and drive `int_en`. The upper bits read zero. A write to this register takes effect even after loading has completed.
- R4: A write of 1 to control bit 0 (enable) opens a session only when both PLL lock inputs are high. Otherwise enable stays 0.
- R5: In an open session with no word pending, a write to 0x250 that has bits 0 and 8 set accepts the data-register value. Bit 8 then reads 1 for exactly STORE_LAT cycles. At the end of that time the word is written at the current address and bit 8 reads 0.
- R6: The word address resets to zero each time a session opens. It advances by one for each stored word and wraps modulo MEM_DEPTH. `pgm_addr` shows the address.
- R7: A request with enable low, or a request while a word is still pending, is ignored. The stored word is the data-register value at the time of acceptance, even if the data register is written again while the word is pending.
- R8: Words are stored bit for bit. An image is packed little-endian: the lowest-addressed byte goes in bits 7:0, and a short final word is zero-filled. `fetch_data` returns the word at `fetch_addr` one clock later.
- R9: Clearing enable after at least one stored word sets control bit 4 (success) and `fw_loaded` exactly DONE_LAT cycles later. Clearing enable with no stored word leaves success clear. Setting enable again during that wait reopens a session and cancels the completion.
- R10: Once success is set it stays set. After that, writes to the control register and the data register have no effect, and no further word is stored.
- R11: Clearing enable while a word is pending abandons that word. It is not stored and the address does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pll_ss_lock | input | 1 | Lock indication of the SuperSpeed PLL |
| pll_hs_lock | input | 1 | Lock indication of the high-speed PLL |
| int_en | output | 3 | Interrupt enable bits |
| pgm_we | output | 1 | Program memory word write strobe |
| pgm_addr | output | clog2(MEM_DEPTH) | Current word address |
| pgm_data | output | 32 | Word being written |
| fw_loaded | output | 1 | Sticky loading-complete flag |
| fetch_addr | input | clog2(MEM_DEPTH) | Controller fetch address |
| fetch_data | output | 32 | Registered fetch data |

## Verification
The download path is driven with three kinds of traffic:
- a seven-byte image, whose packed words show byte order and the zero fill of the short last word;
- a word whose data register is rewritten while the word is pending, followed by a duplicate request, which tells a snapshot at acceptance apart from a late read and a queued second store;
- a run of one more word than the memory holds, which exposes address wrap.

Session control is tried in three ways:
- closing with nothing stored;
- closing and then reopening at once;
- a real close, after which the post-completion writes show whether anything still leaks into registers or memory.

A behavioural model, updated on every clock, also tracks the completion flag, the address and the interrupt-enable bits.

// File: rtl/fwload_pkg.sv
package fwload_pkg;

    localparam int BUS_AW = 12;
    localparam int REG_W  = 32;
    localparam int IRQ_W  = 3;

    localparam logic [BUS_AW-1:0] OFF_PLL  = 12'h104;
    localparam logic [BUS_AW-1:0] OFF_IRQ  = 12'h224;
    localparam logic [BUS_AW-1:0] OFF_CTRL = 12'h250;
    localparam logic [BUS_AW-1:0] OFF_DATA = 12'h258;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_DONE_BIT = 4;
    localparam int CTRL_REQ_BIT  = 8;
    localparam int PLL_SS_BIT    = 16;
    localparam int PLL_HS_BIT    = 0;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_PLL, SEL_IRQ, SEL_CTRL, SEL_DATA
    } reg_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ARMED, ST_STORING, ST_CLOSING, ST_LOADED
    } sess_e;

    typedef struct packed {
        logic en_on;
        logic en_off;
        logic word_req;
    } ctrl_cmd_t;

    typedef struct packed {
        logic en;
        logic busy;
        logic done;
    } sess_status_t;

    function automatic reg_sel_e decode_sel(logic [BUS_AW-1:0] a);
        case (a)
            OFF_PLL:  return SEL_PLL;
            OFF_IRQ:  return SEL_IRQ;
            OFF_CTRL: return SEL_CTRL;
            OFF_DATA: return SEL_DATA;
            default:  return SEL_NONE;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(sess_status_t s);
        logic [REG_W-1:0] r;
        r = '0;
        r[CTRL_EN_BIT]   = s.en;
        r[CTRL_DONE_BIT] = s.done;
        r[CTRL_REQ_BIT]  = s.busy;
        return r;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fwload_csr.sv
module fwload_csr
    import fwload_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [BUS_AW-1:0]   bus_addr,
    input  logic [REG_W-1:0]    bus_wdata,
    input  logic                bus_we,
    input  logic                bus_re,
    input  logic                pll_ss,
    input  logic                pll_hs,
    input  sess_status_t        status,
    output ctrl_cmd_t           cmd,
    output logic [REG_W-1:0]    data_q,
    output logic [IRQ_W-1:0]    irq_q,
    output logic [REG_W-1:0]    rdata
);

    reg_sel_e sel;
    logic     wr_ctrl;

    assign sel     = decode_sel(bus_addr);
    assign wr_ctrl = bus_we && (sel == SEL_CTRL);

    always_comb begin
        cmd.en_on    = wr_ctrl && bus_wdata[CTRL_EN_BIT] && pll_ss && pll_hs;
        cmd.en_off   = wr_ctrl && !bus_wdata[CTRL_EN_BIT];
        cmd.word_req = wr_ctrl && bus_wdata[CTRL_EN_BIT] && bus_wdata[CTRL_REQ_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            irq_q  <= '0;
        end else begin
            if (bus_we && (sel == SEL_DATA) && !status.done)
                data_q <= bus_wdata;
            if (bus_we && (sel == SEL_IRQ))
                irq_q <= bus_wdata[IRQ_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (bus_re) begin
            case (sel)
                SEL_PLL: begin
                    rdata[PLL_SS_BIT] = pll_ss;
                    rdata[PLL_HS_BIT] = pll_hs;
                end
                SEL_IRQ:  rdata[IRQ_W-1:0] = irq_q;
                SEL_CTRL: rdata = pack_ctrl(status);
                SEL_DATA: rdata = data_q;
                default:  rdata = '0;
            endcase
        end
    end

    a_r3_irq_write: assert property (@(posedge clk) disable iff (rst)
        (bus_we && sel == SEL_IRQ) |=> irq_q == $past(bus_wdata[IRQ_W-1:0]));

    a_r10_data_frozen: assert property (@(posedge clk) disable iff (rst)
        status.done |=> $stable(data_q));

endmodule

// File: rtl/fwload_seq.sv
module fwload_seq
    import fwload_pkg::*;
#(
    parameter int MEM_DEPTH = 256,
    parameter int STORE_LAT = 2,
    parameter int DONE_LAT  = 3,
    localparam int AW = $clog2(MEM_DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_cmd_t        cmd,
    input  logic [REG_W-1:0] data_q,
    output sess_status_t     status,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [REG_W-1:0] wr_data
);

    localparam int CW = $clog2(max2(STORE_LAT, DONE_LAT) + 1);

    sess_e            state;
    logic [CW-1:0]    cnt;
    logic [AW-1:0]    addr_q;
    logic             any_q;
    logic [REG_W-1:0] word_q;

    assign wr_en   = (state == ST_STORING) && (cnt == '0) && !cmd.en_off;
    assign wr_addr = addr_q;
    assign wr_data = word_q;

    always_comb begin
        status.en   = (state == ST_ARMED) || (state == ST_STORING);
        status.busy = (state == ST_STORING);
        status.done = (state == ST_LOADED);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            addr_q <= '0;
            any_q  <= 1'b0;
            word_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (cmd.en_on) begin
                        state  <= ST_ARMED;
                        addr_q <= '0;
                        any_q  <= 1'b0;
                    end
                end
                ST_ARMED: begin
                    if (cmd.en_off) begin
                        state <= any_q ? ST_CLOSING : ST_IDLE;
                        cnt   <= CW'(DONE_LAT - 1);
                    end else if (cmd.word_req) begin
                        state  <= ST_STORING;
                        cnt    <= CW'(STORE_LAT - 1);
                        word_q <= data_q;
                    end
                end
                ST_STORING: begin
                    if (cmd.en_off) begin
                        state <= any_q ? ST_CLOSING : ST_IDLE;
                        cnt   <= CW'(DONE_LAT - 1);
                    end else if (cnt == '0) begin
                        state  <= ST_ARMED;
                        addr_q <= addr_q + AW'(1);
                        any_q  <= 1'b1;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                ST_CLOSING: begin
                    if (cmd.en_on) begin
                        state  <= ST_ARMED;
                        addr_q <= '0;
                        any_q  <= 1'b0;
                    end else if (cnt == '0) begin
                        state <= ST_LOADED;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                default: state <= ST_LOADED;
            endcase
        end
    end

    a_r6_addr_step: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> wr_addr == $past(wr_addr) + AW'(1));

    a_r6_addr_zero_on_open: assert property (@(posedge clk) disable iff (rst)
        $rose(status.en) |-> wr_addr == '0);

    a_r9_done_needs_word: assert property (@(posedge clk) disable iff (rst)
        $rose(status.done) |-> $past(any_q));

    a_r10_done_sticky: assert property (@(posedge clk) disable iff (rst)
        status.done |=> status.done);

    a_r10_no_store_after_done: assert property (@(posedge clk) disable iff (rst)
        status.done |-> !wr_en);

    a_r7_word_held: assert property (@(posedge clk) disable iff (rst)
        (status.busy && $past(status.busy)) |-> $stable(wr_data));

endmodule

// File: rtl/fwload_imem.sv
module fwload_imem #(
    parameter int MEM_DEPTH = 256,
    parameter int DW        = 32,
    localparam int AW = $clog2(MEM_DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [MEM_DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else
            rdata <= mem[raddr];
    end

endmodule

// File: rtl/fwload_regif.sv
module fwload_regif
    import fwload_pkg::*;
#(
    parameter int MEM_DEPTH = 256,
    parameter int STORE_LAT = 2,
    parameter int DONE_LAT  = 3,
    localparam int AW = $clog2(MEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              pll_ss_lock,
    input  logic              pll_hs_lock,
    output logic [IRQ_W-1:0]  int_en,
    output logic              pgm_we,
    output logic [AW-1:0]     pgm_addr,
    output logic [REG_W-1:0]  pgm_data,
    output logic              fw_loaded,
    input  logic [AW-1:0]     fetch_addr,
    output logic [REG_W-1:0]  fetch_data
);

    ctrl_cmd_t        cmd;
    sess_status_t     status;
    logic [REG_W-1:0] data_q;

    fwload_csr u_csr (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .pll_ss    (pll_ss_lock),
        .pll_hs    (pll_hs_lock),
        .status    (status),
        .cmd       (cmd),
        .data_q    (data_q),
        .irq_q     (int_en),
        .rdata     (bus_rdata)
    );

    fwload_seq #(
        .MEM_DEPTH (MEM_DEPTH),
        .STORE_LAT (STORE_LAT),
        .DONE_LAT  (DONE_LAT)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .data_q  (data_q),
        .status  (status),
        .wr_en   (pgm_we),
        .wr_addr (pgm_addr),
        .wr_data (pgm_data)
    );

    fwload_imem #(
        .MEM_DEPTH (MEM_DEPTH),
        .DW        (REG_W)
    ) u_imem (
        .clk   (clk),
        .rst   (rst),
        .we    (pgm_we),
        .waddr (pgm_addr),
        .wdata (pgm_data),
        .raddr (fetch_addr),
        .rdata (fetch_data)
    );

    assign fw_loaded = status.done;

    a_r4_open_needs_pll: assert property (@(posedge clk) disable iff (rst)
        $rose(status.en) |-> $past(pll_ss_lock && pll_hs_lock));

    a_r10_loaded_no_enable: assert property (@(posedge clk) disable iff (rst)
        fw_loaded |-> !status.en);

endmodule

// File: tb/fwload_regif_tb.sv
module fwload_regif_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam int SLAT  = 3;
    localparam int DLAT  = 4;
    localparam int AW    = $clog2(DEPTH);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        pll_ss_lock = 1'b0;
    logic        pll_hs_lock = 1'b0;
    logic [2:0]  int_en;
    logic        pgm_we;
    logic [AW-1:0] pgm_addr;
    logic [31:0] pgm_data;
    logic        fw_loaded;
    logic [AW-1:0] fetch_addr = '0;
    logic [31:0] fetch_data;

    int vec = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fwload_regif #(.MEM_DEPTH(DEPTH), .STORE_LAT(SLAT), .DONE_LAT(DLAT)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .pll_ss_lock(pll_ss_lock), .pll_hs_lock(pll_hs_lock), .int_en(int_en),
        .pgm_we(pgm_we), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
        .fw_loaded(fw_loaded), .fetch_addr(fetch_addr), .fetch_data(fetch_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model, advanced on each rising edge
    int m_en, m_pend, m_fin, m_loaded, m_addr, m_any;
    logic [31:0] m_word, m_data;
    logic [2:0]  m_irq;

    always @(posedge clk) begin
        int pb, fb;
        if (rst) begin
            m_en = 0; m_pend = 0; m_fin = 0; m_loaded = 0; m_addr = 0; m_any = 0;
            m_word = '0; m_data = '0; m_irq = '0;
        end else begin
            pb = m_pend;
            fb = m_fin;
            if (bus_we && bus_addr == 12'h224) m_irq = bus_wdata[2:0];
            if (bus_we && bus_addr == 12'h258 && m_loaded == 0) m_data = bus_wdata;
            if (bus_we && bus_addr == 12'h250 && m_loaded == 0) begin
                if (m_en == 0) begin
                    if (bus_wdata[0] && pll_ss_lock && pll_hs_lock) begin
                        m_en = 1; m_addr = 0; m_any = 0; m_fin = 0;
                    end
                end else if (!bus_wdata[0]) begin
                    m_en = 0; m_pend = 0;
                    m_fin = (m_any != 0) ? DLAT : 0;
                end else if (bus_wdata[8] && m_pend == 0) begin
                    m_pend = SLAT; m_word = m_data;
                end
            end
            if (pb > 0 && m_pend > 0) begin
                m_pend--;
                if (m_pend == 0) begin
                    m_addr = (m_addr + 1) % DEPTH;
                    m_any = 1;
                end
            end
            if (fb > 0 && m_fin > 0) begin
                m_fin--;
                if (m_fin == 0) m_loaded = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk("R9/R10 fw_loaded vs model", {31'b0, fw_loaded}, 32'(m_loaded));
            chk("R6 pgm_addr vs model", 32'(pgm_addr), 32'(m_addr));
            chk("R3 int_en vs model", {29'b0, int_en}, {29'b0, m_irq});
        end
    end

    // all bus tasks start and end at a falling edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        bus_addr = a; bus_re = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic wait_idle(output int ones);
        logic [31:0] v;
        ones = 0;
        do begin
            rd(12'h250, v);
            if (v[8]) ones++;
        end while (v[8] && ones < 100);
    endtask

    task automatic fetch(input int a, input logic [31:0] exp, input string tag);
        fetch_addr = AW'(a);
        @(negedge clk);
        chk(tag, fetch_data, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        vec++; bad++;
        $display("FAIL watchdog R1..all act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  img [7];
        int n;
        logic [31:0] w;

        idle(3);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(12'h250, v); chk("R1 ctrl after reset", v, 32'h0);
        rd(12'h258, v); chk("R1 data after reset", v, 32'h0);
        rd(12'h224, v); chk("R1 irq after reset", v, 32'h0);
        chk("R1 fw_loaded after reset", {31'b0, fw_loaded}, 32'h0);
        chk("R1 pgm_addr after reset", 32'(pgm_addr), 32'h0);

        // R2 status and undefined offsets
        rd(12'h104, v); chk("R2 pll none", v, 32'h0);
        pll_ss_lock = 1'b1;
        rd(12'h104, v); chk("R2 pll ss only", v, 32'h0001_0000);
        pll_ss_lock = 1'b0; pll_hs_lock = 1'b1;
        rd(12'h104, v); chk("R2 pll hs only", v, 32'h0000_0001);
        pll_ss_lock = 1'b1;
        rd(12'h104, v); chk("R2 pll both", v, 32'h0001_0001);
        rd(12'h300, v); chk("R2 undefined 0x300", v, 32'h0);
        rd(12'h254, v); chk("R2 undefined 0x254", v, 32'h0);
        bus_addr = 12'h104; #1 chk("R2 no strobe reads zero", bus_rdata, 32'h0);
        @(negedge clk);

        // R3 interrupt enables
        wr(12'h224, 32'hFFFF_FFFF);
        rd(12'h224, v); chk("R3 irq upper bits zero", v, 32'h7);
        chk("R3 int_en port", {29'b0, int_en}, 32'h7);
        wr(12'h224, v & ~32'h2);
        rd(12'h224, v); chk("R3 irq read-modify-write", v, 32'h5);

        // R4 enable blocked without both locks
        pll_hs_lock = 1'b0;
        wr(12'h250, 32'h1);
        rd(12'h250, v); chk("R4 enable blocked by pll", v, 32'h0);
        pll_hs_lock = 1'b1;

        // R7 request with enable low
        wr(12'h250, 32'h100);
        rd(12'h250, v); chk("R7 request with enable low", v, 32'h0);

        // R11 / R9: abandon the only word, no completion
        wr(12'h250, 32'h1);
        rd(12'h250, v); chk("R4 enable opens session", v, 32'h1);
        wr(12'h258, 32'h1234_5678);
        wr(12'h250, 32'h101);
        wr(12'h250, 32'h0);
        idle(DLAT + 3);
        rd(12'h250, v); chk("R9 no success without stored word", v, 32'h0);
        chk("R11 abandoned word not stored", 32'(pgm_addr), 32'h0);

        // session B: seven-byte image, little-endian packing
        wr(12'h250, 32'h1);
        for (int k = 0; k < 7; k++) img[k] = 8'(8'h11 * (k + 1));
        for (int i = 0; i < 2; i++) begin
            w = '0;
            for (int j = 0; j < 4; j++)
                if (i*4 + j < 7) w[8*j +: 8] = img[i*4 + j];
            wr(12'h258, w);
            wr(12'h250, 32'h101);
            wait_idle(n);
            if (i == 0) chk("R5 request bit busy cycles", 32'(n), 32'(SLAT));
            chk("R6 address after store", 32'(pgm_addr), 32'(i + 1));
        end
        // R7 snapshot and duplicate request while pending
        wr(12'h258, 32'hCAFE_0001);
        wr(12'h250, 32'h101);
        wr(12'h258, 32'hDEAD_BEEF);
        wr(12'h250, 32'h101);
        wait_idle(n);
        chk("R7 duplicate request ignored", 32'(pgm_addr), 32'h3);
        rd(12'h258, v); chk("R7 data register rewritten", v, 32'hDEAD_BEEF);
        fetch(0, 32'h4433_2211, "R8 word0 little-endian");
        fetch(1, 32'h0077_6655, "R8 partial word zero-filled");
        fetch(2, 32'hCAFE_0001, "R7 snapshot at acceptance");

        // R9 reopen during closing cancels completion
        wr(12'h250, 32'h0);
        wr(12'h250, 32'h1);
        chk("R6 address zero on reopen", 32'(pgm_addr), 32'h0);
        idle(DLAT + 2);
        rd(12'h250, v); chk("R9 reopen cancels completion", v, 32'h1);

        // session C: wrap
        for (int i = 0; i < DEPTH + 1; i++) begin
            wr(12'h258, 32'hC0DE_0000 + 32'(i));
            wr(12'h250, 32'h101);
            wait_idle(n);
        end
        chk("R6 address wraps", 32'(pgm_addr), 32'h1);
        fetch(0, 32'hC0DE_0008, "R6 wrapped word overwrote slot 0");
        fetch(1, 32'hC0DE_0001, "R8 slot 1 contents");
        fetch(DEPTH - 1, 32'hC0DE_0007, "R8 last slot contents");

        // R9 completion timing
        wr(12'h250, 32'h0);
        n = 0;
        do begin
            rd(12'h250, v);
            if (!v[4]) n++;
        end while (!v[4] && n < 50);
        chk("R9 success delay", 32'(n), 32'(DLAT));
        chk("R9 success register value", v, 32'h10);

        // R10 lock after completion
        wr(12'h250, 32'h101);
        rd(12'h250, v); chk("R10 control write ignored", v, 32'h10);
        wr(12'h258, 32'h0);
        rd(12'h258, v); chk("R10 data write ignored", v, 32'hC0DE_0008);
        idle(SLAT + 2);
        chk("R10 no store after completion", 32'(pgm_addr), 32'h1);
        fetch(1, 32'hC0DE_0001, "R10 memory untouched");
        wr(12'h224, 32'h2);
        rd(12'h224, v); chk("R3 irq writable after completion", v, 32'h2);
        chk("R10 fw_loaded held", {31'b0, fw_loaded}, 32'h1);

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule